// File: doc/BRIEF.md
# Time-multiplexed multicast line port

This block is the per-chip end of a small shared interconnect that links a handful of logic-emulation chips. All chips see the same few bit lines and the same fast micro-clock. Within each period of the slower emulation clock, a schedule table divides time into transfer slots. For every slot and every line, the table says whether this chip puts one of its local signals on that line, and whether it latches the line's value into one of its remote-signal registers. Because any number of chips may capture the same slot, one drive reaches many destinations at once.

An emulation-clock edge arrives as a one-micro-cycle pulse and restarts the sequence at slot zero. The sequence then runs up to a programmable last slot and stops, leaving every line released until the next pulse. If the lines are too few for the signals, a longer schedule is loaded. Each slot lasts two micro-cycles, and capture happens at the end of the second. The drive register takes a fresh local value on every micro-cycle, so a signal computed from a value captured in one slot can leave the chip in the very next slot. Schedule entries are written through a plain synchronous write port. The table sits in a synchronous-read memory.

Top module: `tmx_port`

## Requirements
- R1: While `rst` is high at a clock edge, `remote_q` and `line_oe` clear to zero and the sequencer goes idle.
- R2: An `emu_tick` sampled high at edge E0 restarts the sequence at slot 0 and latches `last_slot` as the period's last slot Te. This happens even in the middle of a running sequence.
- R3: Slot s occupies two micro-cycles. A line scheduled to be driven in slot s has its `line_oe` bit high from edge E(2s+1) through edge E(2s+3), and low before E1.
- R4: Capture takes `line_in` at edge E(2s+3) into `remote_q[dst]` for every line whose capture bit is set in slot s. Several ports can capture one driven line in the same slot (multicast).
- R5: Slots above Te are never executed. From edge E(2Te+3) until the next tick, all `line_oe` bits are zero.
- R6: In a slot where a line's drive bit is clear, the port leaves that line released (`line_oe` bit low). A correct schedule has at most one driver per line per slot.
- R7: `line_out` takes `local_sig[src]` again on every micro-cycle of the slot. A local value that depends on a capture in slot s therefore arrives at its destination when it is scheduled in slot s+1.
- R8: A `remote_q` bit keeps its value in every cycle in which no capture targets it, including while the port is idle and local inputs change.
- R9: If two lines capture into the same destination bit in one slot, the higher-numbered line wins.
- R10: `sched_we` writes `sched_wdata` into slot `sched_addr`. Line l uses bits [l*LF +: LF], where LF = 2 + SRC_W + DST_W. Inside that field, bits [DST_W-1:0] hold the destination index, bit DST_W is the capture enable, the next SRC_W bits hold the source index, and the top bit is the drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Micro-clock |
| rst | input | 1 | Synchronous active-high reset |
| emu_tick | input | 1 | One-cycle pulse marking an emulation clock edge |
| last_slot | input | SLOT_W | Last slot index Te, latched on `emu_tick` |
| sched_we | input | 1 | Schedule write enable |
| sched_addr | input | SLOT_W | Schedule slot to write |
| sched_wdata | input | ENT_W | Schedule entry (per-line fields, see R10) |
| local_sig | input | NLOC | Local signals available for sending |
| line_in | input | LINES | Resolved value of the shared lines |
| line_out | output | LINES | Value driven onto each line |
| line_oe | output | LINES | Drive enable per line (low means released) |
| remote_q | output | NREM | Registers holding captured remote signals |

## Verification
On every cycle, the assertions check the sequencer's behaviour: a restart on each tick, two micro-cycles per slot, and never running past the latched Te. They also check that the lines are released while the port is idle, and that captured registers hold outside capture cycles. Only the bench scenarios, with three ports on a wired bus, can show the rest. These are the exact drive windows, multicast delivery to every destination, the chain from a capture to the next slot's send, the line priority on colliding captures, the Te cutoff and the absence of double drivers.

// File: rtl/tmx_pkg.sv
package tmx_pkg;
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_t;
endpackage

// File: rtl/tmx_slot_seq.sv
module tmx_slot_seq
  import tmx_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [SLOT_W-1:0] last_slot,
  output logic [SLOT_W-1:0] slot_q,
  output phase_t            phase_q,
  output logic              active_q,
  output logic [SLOT_W-1:0] rd_slot
);
  logic [SLOT_W-1:0] te_q, n_te, n_slot;
  phase_t            n_phase;
  logic              n_active;

  always_comb begin
    n_te     = te_q;
    n_slot   = slot_q;
    n_phase  = phase_q;
    n_active = active_q;
    if (tick) begin
      n_te     = last_slot;
      n_slot   = '0;
      n_phase  = PH_A;
      n_active = 1'b1;
    end else if (active_q) begin
      if (phase_q == PH_A) begin
        n_phase = PH_B;
      end else begin
        n_phase = PH_A;
        if (slot_q >= te_q) n_active = 1'b0;
        else                n_slot   = slot_q + 1'b1;
      end
    end
  end

  assign rd_slot = n_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      te_q     <= '0;
      slot_q   <= '0;
      phase_q  <= PH_A;
      active_q <= 1'b0;
    end else begin
      te_q     <= n_te;
      slot_q   <= n_slot;
      phase_q  <= n_phase;
      active_q <= n_active;
    end
  end

  // R2: a tick always restarts at slot 0, first half
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    tick |=> (active_q && slot_q == '0 && phase_q == PH_A));

  // R3: the first half of a slot is followed by its second half
  a_r3_two_cycle: assert property (@(posedge clk) disable iff (rst)
    (active_q && phase_q == PH_A && !tick) |=> (active_q && phase_q == PH_B && $stable(slot_q)));

  // R5: never past the latched last slot
  a_r5_within_te: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (slot_q <= te_q));
endmodule

// File: rtl/tmx_sched_mem.sv
module tmx_sched_mem #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // R10: plain synchronous write, registered read (block-RAM shape)
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tmx_line_drv.sv
module tmx_line_drv #(
  parameter int LINES = 4,
  parameter int NLOC  = 8,
  parameter int NREM  = 8,
  localparam int SRC_W = $clog2(NLOC),
  localparam int DST_W = $clog2(NREM),
  localparam int LF    = 2 + SRC_W + DST_W,
  localparam int ENT_W = LINES * LF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [ENT_W-1:0] ent,
  input  logic [NLOC-1:0]  local_sig,
  output logic [LINES-1:0] line_out,
  output logic [LINES-1:0] line_oe
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic             drv;
    logic [SRC_W-1:0] src;
    assign drv = ent[l*LF + LF - 1];
    assign src = ent[l*LF + DST_W + 1 +: SRC_W];

    // R6 / R7: released unless scheduled; the source is resampled every micro-cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        line_oe[l]  <= 1'b0;
        line_out[l] <= 1'b0;
      end else begin
        line_oe[l]  <= active & drv;
        line_out[l] <= active & drv & local_sig[src];
      end
    end
  end
endmodule

// File: rtl/tmx_capture.sv
module tmx_capture
  import tmx_pkg::*;
#(
  parameter int LINES = 4,
  parameter int NLOC  = 8,
  parameter int NREM  = 8,
  localparam int SRC_W = $clog2(NLOC),
  localparam int DST_W = $clog2(NREM),
  localparam int LF    = 2 + SRC_W + DST_W,
  localparam int ENT_W = LINES * LF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  phase_t           phase,
  input  logic [ENT_W-1:0] ent,
  input  logic [LINES-1:0] line_in,
  output logic [NREM-1:0]  remote_q
);
  logic [ENT_W-1:0] ent_d;
  phase_t           ph_d;
  logic             act_d;
  logic             cap_now;

  assign cap_now = act_d && (ph_d == PH_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_d    <= '0;
      ph_d     <= PH_A;
      act_d    <= 1'b0;
      remote_q <= '0;
    end else begin
      ent_d <= ent;
      ph_d  <= phase;
      act_d <= active;
      if (cap_now) begin
        // R4 / R9: ascending loop, so the highest line takes a shared destination
        for (int l = 0; l < LINES; l++) begin
          if (ent_d[l*LF + DST_W])
            remote_q[ent_d[l*LF +: DST_W]] <= line_in[l];
        end
      end
    end
  end

  // R8: outside capture cycles, captured values hold
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_now |=> $stable(remote_q));
endmodule

// File: rtl/tmx_port.sv
module tmx_port
  import tmx_pkg::*;
#(
  parameter int LINES     = 4,
  parameter int NLOC      = 8,
  parameter int NREM      = 8,
  parameter int MAX_SLOTS = 16,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int SRC_W    = $clog2(NLOC),
  localparam int DST_W    = $clog2(NREM),
  localparam int LF       = 2 + SRC_W + DST_W,
  localparam int ENT_W    = LINES * LF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              emu_tick,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic              sched_we,
  input  logic [SLOT_W-1:0] sched_addr,
  input  logic [ENT_W-1:0]  sched_wdata,
  input  logic [NLOC-1:0]   local_sig,
  input  logic [LINES-1:0]  line_in,
  output logic [LINES-1:0]  line_out,
  output logic [LINES-1:0]  line_oe,
  output logic [NREM-1:0]   remote_q
);
  logic [SLOT_W-1:0] slot_q, rd_slot;
  phase_t            phase_q;
  logic              act_q;
  logic [ENT_W-1:0]  ent_q;

  tmx_slot_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst(rst), .tick(emu_tick), .last_slot(last_slot),
    .slot_q(slot_q), .phase_q(phase_q), .active_q(act_q), .rd_slot(rd_slot)
  );

  tmx_sched_mem #(.DEPTH(MAX_SLOTS), .WIDTH(ENT_W)) u_mem (
    .clk(clk), .we(sched_we), .waddr(sched_addr), .wdata(sched_wdata),
    .raddr(rd_slot), .rdata(ent_q)
  );

  tmx_line_drv #(.LINES(LINES), .NLOC(NLOC), .NREM(NREM)) u_drv (
    .clk(clk), .rst(rst), .active(act_q), .ent(ent_q),
    .local_sig(local_sig), .line_out(line_out), .line_oe(line_oe)
  );

  tmx_capture #(.LINES(LINES), .NLOC(NLOC), .NREM(NREM)) u_cap (
    .clk(clk), .rst(rst), .active(act_q), .phase(phase_q), .ent(ent_q),
    .line_in(line_in), .remote_q(remote_q)
  );

  // R5: an idle sequencer leaves every line released in the next cycle
  a_r5_idle_release: assert property (@(posedge clk) disable iff (rst)
    !act_q |=> (line_oe == '0));

  // R1: reset leaves the lines released and the capture registers clear
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (line_oe == '0 && remote_q == '0));
endmodule

// File: tb/test_tmx_port.sv
`timescale 1ns/1ps
module test_tmx_port;
  localparam int NP = 3, L = 4, NL = 8, NR = 8, MS = 16, SW = 4, LF = 8, EW = 32;
  localparam logic [7:0] P0_V = 8'hA5, P2_V = 8'h96;
  localparam logic [6:0] P1_LO = 7'h3C;
  // {slot[3:0], line[1:0], src port[1:0], src idx[2:0], dst port mask[2:0], dst idx[2:0]}
  localparam logic [16:0] VEC [8] = '{
    {4'd0, 2'd0, 2'd0, 3'd0, 3'b110, 3'd0},
    {4'd0, 2'd1, 2'd2, 3'd1, 3'b001, 3'd1},
    {4'd0, 2'd2, 2'd1, 3'd2, 3'b101, 3'd2},
    {4'd1, 2'd0, 2'd1, 3'd7, 3'b001, 3'd3},
    {4'd1, 2'd3, 2'd0, 3'd5, 3'b110, 3'd4},
    {4'd2, 2'd1, 2'd2, 3'd4, 3'b011, 3'd5},
    {4'd3, 2'd3, 2'd1, 3'd3, 3'b100, 3'd6},
    {4'd3, 2'd0, 2'd0, 3'd1, 3'b010, 3'd7}
  };

  logic clk = 0, rst = 1, tick = 0;
  logic [SW-1:0] last_slot = '0, waddr = '0;
  logic [EW-1:0] wdata = '0;
  logic we [NP];
  logic [NL-1:0] loc [NP];
  logic [NL-1:0] loc0 = P0_V;
  logic [L-1:0] oe_a [NP], out_a [NP];
  logic [NR-1:0] rem_a [NP];
  logic [L-1:0] bus;
  logic [EW-1:0] sh [NP][MS];
  int checks = 0, failures = 0, conflicts = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    loc[0] = loc0;
    loc[1] = {rem_a[1][0], P1_LO};
    loc[2] = P2_V;
    for (int l = 0; l < L; l++) begin
      bus[l] = 1'b0;
      for (int p = 0; p < NP; p++) bus[l] = bus[l] | (oe_a[p][l] & out_a[p][l]);
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_port
    tmx_port #(.LINES(L), .NLOC(NL), .NREM(NR), .MAX_SLOTS(MS)) i_tmx_port (
      .clk(clk), .rst(rst), .emu_tick(tick), .last_slot(last_slot),
      .sched_we(we[k]), .sched_addr(waddr), .sched_wdata(wdata),
      .local_sig(loc[k]), .line_in(bus),
      .line_out(out_a[k]), .line_oe(oe_a[k]), .remote_q(rem_a[k])
    );
  end

  // R6: a single driver per line in every cycle
  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < L; l++) begin
        if ((32'(oe_a[0][l]) + 32'(oe_a[1][l]) + 32'(oe_a[2][l])) > 1) conflicts++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_val(input int sp, input int si);
    if (sp == 0) return P0_V[si];
    if (sp == 1) return (si == 7) ? P0_V[0] : P1_LO[si];
    return P2_V[si];
  endfunction

  task automatic set_drv(input int p, input int s, input int l, input int idx);
    sh[p][s][l*LF + 7] = 1'b1;
    sh[p][s][l*LF + 4 +: 3] = 3'(idx);
  endtask

  task automatic set_cap(input int p, input int s, input int l, input int d);
    sh[p][s][l*LF + 3] = 1'b1;
    sh[p][s][l*LF +: 3] = 3'(d);
  endtask

  // R10: load every slot of every port through the write port
  task automatic load_all();
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < MS; s++) begin
        @(negedge clk);
        we[p] = 1'b1; waddr = SW'(s); wdata = sh[p][s];
        @(negedge clk);
        we[p] = 1'b0;
      end
    end
  endtask

  task automatic pulse(input int te);
    last_slot = SW'(te);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      we[p] = 1'b0;
      for (int s = 0; s < MS; s++) sh[p][s] = '0;
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk($sformatf("R1 reset remote p%0d", p), 32'(rem_a[p]), 0);
      chk($sformatf("R1 reset oe p%0d", p), 32'(oe_a[p]), 0);
    end

    for (int r = 0; r < 8; r++) begin
      logic [16:0] v;
      v = VEC[r];
      set_drv(int'(v[10:9]), int'(v[16:13]), int'(v[12:11]), int'(v[8:6]));
      for (int p = 0; p < NP; p++)
        if (v[3+p]) set_cap(p, int'(v[16:13]), int'(v[12:11]), int'(v[2:0]));
    end
    load_all();

    // R3 / R6: drive windows in the first period (Te = 3)
    pulse(3);
    chk("R3 no drive before E1", 32'(oe_a[0] | oe_a[1] | oe_a[2]), 0);
    @(negedge clk);
    chk("R3 slot0 p0 oe", 32'(oe_a[0]), 32'h1);
    chk("R6 slot0 p2 oe", 32'(oe_a[2]), 32'h2);
    chk("R6 slot0 p1 oe", 32'(oe_a[1]), 32'h4);
    @(negedge clk);
    chk("R3 slot0 second cycle p0 oe", 32'(oe_a[0]), 32'h1);
    @(negedge clk);
    chk("R3 slot1 p0 oe", 32'(oe_a[0]), 32'h8);
    chk("R3 slot1 p1 oe", 32'(oe_a[1]), 32'h1);
    chk("R6 slot1 p2 released", 32'(oe_a[2]), 0);
    repeat (10) @(negedge clk);

    // R4 / R7: every destination of every vector holds the driven value
    for (int r = 0; r < 8; r++) begin
      logic [16:0] v;
      v = VEC[r];
      for (int p = 0; p < NP; p++)
        if (v[3+p])
          chk($sformatf("R4/R7 vec%0d dst p%0d", r, p), 32'(rem_a[p][v[2:0]]),
              32'(exp_val(int'(v[10:9]), int'(v[8:6]))));
    end
    for (int p = 0; p < NP; p++)
      chk($sformatf("R5 idle released p%0d", p), 32'(oe_a[p]), 0);

    // R5 / R9: slots 4 and 5, executed only when Te reaches them
    set_drv(2, 4, 1, 0); set_drv(0, 4, 3, 0);
    set_cap(1, 4, 1, 6); set_cap(1, 4, 3, 6);
    set_drv(0, 5, 2, 0); set_cap(2, 5, 2, 7);
    load_all();
    pulse(3);
    repeat (12) @(negedge clk);
    chk("R5 slot5 skipped at Te=3", 32'(rem_a[2][7]), 0);
    chk("R5 slot4 skipped at Te=3", 32'(rem_a[1][6]), 0);
    pulse(5);
    repeat (16) @(negedge clk);
    chk("R4 last slot captured at Te=5", 32'(rem_a[2][7]), 1);
    chk("R9 higher line wins", 32'(rem_a[1][6]), 1);

    // R2: a tick during slot 1 restarts at slot 0
    pulse(5);
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    chk("R2 restart p0 drives slot0 again", 32'(oe_a[0]), 32'h1);
    chk("R2 restart p1 in slot0", 32'(oe_a[1]), 32'h4);
    repeat (16) @(negedge clk);

    // R8: idle port keeps captured values while local inputs change
    loc0 = 8'h00;
    repeat (10) @(negedge clk);
    chk("R8 hold p1 rem0", 32'(rem_a[1][0]), 1);
    chk("R8 hold p2 rem0", 32'(rem_a[2][0]), 1);
    chk("R5 idle released after hold", 32'(oe_a[0] | oe_a[1] | oe_a[2]), 0);
    chk("R6 no double driver", 32'(conflicts), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule